// File: doc/BRIEF.md
# Fractional SPI bit-rate generator

This block produces the bit-rate enable for a serial controller running from a fast controller clock. It emits a tick one clock cycle wide. The serial engine advances by one half bit period on each tick. The tick rate equals the controller clock frequency multiplied by a rate code and divided by 512. The rate code is an 8-bit value taken from bits 31:24 of the selected device slot's parameter word. The legal codes are the powers of two from 1 to 128, which span rates from 1/512 of the clock up to one quarter of it.

The rate is generated by a 9-bit phase accumulator. It adds the code on every running cycle and emits a tick on each carry out of its top bit. The code is captured only while the generator is idle, so a new rate applies from the next transaction and never shortens a bit period during a transfer. The accumulator sits at zero while idle. Each transfer therefore starts with a full first period.

Top module: `bitrate_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `tick` is 0 and `idle` is 1.
- R2: `idle` is the inverse of `en` delayed by one clock edge. It goes to 0 after the edge on which `en` is first sampled high, and it returns to 1 after the edge on which `en` is sampled low.
- R3: Call the edge on which `en` is first sampled high the start edge, and take a power-of-two code c. Then `tick` is 1 in the cycle after edges P, 2P, 3P and so on past the start edge, where P = 512/c, and it is 0 in every other cycle. Code 128 gives P=4 and code 1 gives P=512.
- R4: `tick` is never high in two consecutive cycles.
- R5: A code that is not a power of two acts as its highest set bit. For example, 0x5A acts as 64 and 0xFF acts as 128. Code 0 acts as 1.
- R6: The code is captured on the start edge. Changing `rate_code` while `en` stays high has no effect on the tick pattern.
- R7: When `en` is lowered and raised again, the phase restarts. The first tick after the new start edge comes a full P cycles later, whatever the phase was before.
- R8: While `idle` is 1, `tick` stays 0 for any `rate_code` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Transfer running; held high for the length of a transaction |
| rate_code | input | 8 | Rate code of the selected device slot (parameter word bits 31:24) |
| tick | output | 1 | Single-cycle half-bit enable |
| idle | output | 1 | High while the generator is not running |

## Verification
The assertions check four things on every cycle: a tick never appears while idle, ticks are never adjacent, the captured code stays one-hot and unchanged while running, and the accumulator is at zero after any cycle without stepping. The exact period for each code, the P-cycle offset of the first tick after a restart, the rounding of non-power-of-two and zero codes, and the fact that mid-transfer code changes have no effect on the tick pattern are shown only by the bench. It compares the tick sequence of each run with a period computed from the code.

// File: rtl/bitrate_pkg.sv
package bitrate_pkg;
    localparam int RATE_W = 8;
    localparam int PHASE_W = RATE_W + 1;
endpackage

// File: rtl/rate_norm.sv
module rate_norm #(
    parameter int CODE_W = bitrate_pkg::RATE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] code_o
);
    logic [CODE_W-1:0] norm_d;

    always_comb begin
        norm_d = CODE_W'(1);
        for (int i = 0; i < CODE_W; i++) begin
            if (code_i[i]) begin
                norm_d = CODE_W'(1) << i;
            end
        end
    end

    assign code_o = norm_d;

    // R5: the normalised code always has exactly one bit set
    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r5_code_onehot: assert ($countones(code_o) == 1)
                else $error("normalised code not one-hot");
        end
    end
endmodule

// File: rtl/phase_acc.sv
module phase_acc #(
    parameter int CODE_W = bitrate_pkg::RATE_W,
    localparam int ACC_W = CODE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [CODE_W-1:0] inc_i,
    output logic              tick_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             tick;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [ACC_W:0] sum;

    always_comb begin
        sum  = {1'b0, st_q.acc} + (ACC_W+1)'(inc_i);
        st_d = st_q;
        if (step_i) begin
            st_d.acc  = sum[ACC_W-1:0];
            st_d.tick = sum[ACC_W];
        end else begin
            st_d.acc  = '0;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;

    // R7: phase returns to zero after any cycle without stepping
    a_r7_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(step_i) |-> st_q.acc == '0);

    // R4: with a code no larger than half the phase range, ticks never touch
    a_r4_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/bitrate_gen.sv
module bitrate_gen #(
    parameter int CODE_W = bitrate_pkg::RATE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CODE_W-1:0] rate_code,
    output logic              tick,
    output logic              idle
);
    typedef struct packed {
        logic              run;
        logic [CODE_W-1:0] code;
    } ctl_state_t;

    ctl_state_t ctl_d, ctl_q;
    logic [CODE_W-1:0] norm_code;
    logic              step;

    rate_norm #(.CODE_W(CODE_W)) i_norm (
        .clk    (clk),
        .rst_n  (rst_n),
        .code_i (rate_code),
        .code_o (norm_code)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.run = en;
        if (!ctl_q.run) begin
            ctl_d.code = norm_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.code <= CODE_W'(1);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign step = ctl_q.run && en;

    phase_acc #(.CODE_W(CODE_W)) i_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .inc_i  (ctl_q.code),
        .tick_o (tick)
    );

    assign idle = !ctl_q.run;

    // R8: no tick while idle
    a_r8_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !tick);

    // R6: captured code frozen while running
    a_r6_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.run && $past(ctl_q.run) |-> $stable(ctl_q.code));
endmodule

// File: tb/test_bitrate_gen.sv
module test_bitrate_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] rate_code = 8'h00;
    logic       tick;
    logic       idle;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    bitrate_gen i_bitrate_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .rate_code (rate_code),
        .tick      (tick),
        .idle      (idle)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int eff_code(input logic [7:0] c);
        int r = 1;
        for (int i = 0; i < 8; i++) if (c[i]) r = 1 << i;
        return r;
    endfunction

    function automatic int period_of(input logic [7:0] c);
        return 512 / eff_code(c);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Starts a run at a negedge; samples n cycles; optionally changes the code mid-run
    task automatic run_seq(input logic [7:0] code, input int n, input bit change,
                           input logic [7:0] new_code, input string req);
        int p = period_of(code);
        int bad = 0;
        int first_bad_k = -1;
        int first_bad_v = 0;
        en = 1'b1;
        rate_code = code;
        for (int i = 1; i <= n; i++) begin
            int k = i - 1;
            bit exp_t;
            @(negedge clk);
            exp_t = (k > 0) && (k % p == 0);
            if (tick !== exp_t || idle !== 1'b0) begin
                if (bad == 0) begin
                    first_bad_k = k;
                    first_bad_v = int'(tick);
                end
                bad++;
            end
            if (change && i == n/2) rate_code = new_code;
        end
        check(bad == 0, req, first_bad_v, first_bad_k);
        en = 1'b0;
        @(negedge clk);
        check(tick === 1'b0 && idle === 1'b1, "R2", int'(idle), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(tick === 1'b0 && idle === 1'b1, "R1", int'(tick), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tick === 1'b0 && idle === 1'b1, "R1", int'(idle), 1);

        // R8: idle with varying codes never ticks
        for (int i = 0; i < 40; i++) begin
            rate_code = 8'(i * 37);
            @(negedge clk);
            check(tick === 1'b0 && idle === 1'b1, "R8", int'(tick), 0);
        end

        // R2: idle drops one edge after en rises
        en = 1'b1;
        rate_code = 8'd128;
        @(negedge clk);
        check(idle === 1'b0, "R2", int'(idle), 0);
        en = 1'b0;
        @(negedge clk);
        check(idle === 1'b1, "R2", int'(idle), 1);

        // R3 directed codes, all powers of two
        for (int b = 0; b < 8; b++) begin
            run_seq(8'(1 << b), 3 * (512 >> b) + 3, 1'b0, 8'h00, "R3");
            repeat (2) @(negedge clk);
        end
        // R4 fastest rate over long run
        run_seq(8'd128, 200, 1'b0, 8'h00, "R4");
        // R5 non-power-of-two and zero codes
        run_seq(8'h5A, 40, 1'b0, 8'h00, "R5");
        run_seq(8'hFF, 30, 1'b0, 8'h00, "R5");
        run_seq(8'h00, 1100, 1'b0, 8'h00, "R5");
        run_seq(8'h03, 600, 1'b0, 8'h00, "R5");
        // R6 mid-run code changes ignored
        run_seq(8'd4, 700, 1'b1, 8'd128, "R6");
        run_seq(8'd128, 100, 1'b1, 8'd1, "R6");
        // R7 restart phase: short run, immediate restart
        run_seq(8'd16, 45, 1'b0, 8'h00, "R7");
        run_seq(8'd16, 70, 1'b0, 8'h00, "R7");
        run_seq(8'd32, 3, 1'b0, 8'h00, "R7");
        run_seq(8'd32, 50, 1'b0, 8'h00, "R7");

        // Random runs
        void'($urandom(32'd1234));
        for (int r = 0; r < 40; r++) begin
            logic [7:0] c = 8'($urandom);
            int len = 10 + int'($urandom % 1200);
            bit chg = 1'($urandom);
            run_seq(c, len, chg, 8'($urandom), "R3");
            repeat (int'($urandom % 5)) begin
                rate_code = 8'($urandom);
                @(negedge clk);
                check(tick === 1'b0 && idle === 1'b1, "R8", int'(tick), 0);
            end
        end

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule